// File: doc/BRIEF.md
# Interrupt Enable and Acknowledge Sequencer

This block keeps the interrupt state of an 8-bit processor core: the two enable flip-flops (IFF1 gates maskable requests, IFF2 keeps a saved copy), the maskable interrupt mode, and the pending state of the non-maskable line. At each instruction boundary it applies the control event decoded from the instruction that just finished. It then decides whether a non-maskable or a maskable request is served. If one is, it runs the whole response cycle by cycle.

The response covers the acknowledge window and the sampling of the data bus. It pushes the return address through a byte-wide write port and, in vectored mode, reads a 16-bit target from a table through the read port. The new program counter appears on the last cycle of the service. The core stays idle while the sequencer is busy. The core performs the stack pop of a return instruction itself; this block only updates the enable flip-flops for it.

Top module: `irq_ack_sequencer`

## Requirements
- R1: After reset IFF1=0, IFF2=0 and the mode is 0. A disable event at a boundary clears both flip-flops. An enable event sets both.
- R2: A maskable request is not accepted at the boundary that carries the enable event. It is accepted at the next boundary if it is still asserted.
- R3: A rising edge on `nmi_i` makes a non-maskable request pending. It is served at the next idle boundary whatever IFF1 is. Serving it copies IFF1 into IFF2, clears IFF1, jumps to 0x0066 and takes 11 cycles.
- R4: Both return events (`ev_retn_i`, `ev_reti_i`) load IFF1 from IFF2. A maskable request is not accepted at the boundary that carries `ev_retn_i`.
- R5: A maskable request (`int_i` high) is ignored while IFF1 is 0. Accepting one clears IFF1 and leaves IFF2 unchanged.
- R6: When a non-maskable request is pending and `int_i` is high at the same boundary, the non-maskable service runs.
- R7: `im_sel_i` with `ev_im_i` sets the mode. Codes 000, 001, 100 and 101 give mode 0, codes 010 and 110 give mode 1, codes 011 and 111 give mode 2. `imode_o` shows 0, 1 or 2.
- R8: Service cycles are numbered from 0, starting in the cycle after the accepting boundary. In a maskable service `ack_o` is high in cycles 0 to 5, and `dbus_i` is sampled in cycle 5. `done_o` is high only in the last cycle, and `new_pc_o` is valid there.
- R9: In mode 0 the sampled byte is a restart opcode with bits [5:3] = t. The service jumps to t×8 and takes 13 cycles.
- R10: Mode 1 jumps to 0x0038 and takes 13 cycles.
- R11: Mode 2 forms the pointer {I, V with bit 0 cleared}. It reads the low target byte at the pointer in cycle 13 and the high byte at pointer+1 in cycle 16, and takes 19 cycles.
- R12: The push writes PC[15:8] to SP−1 and then, 3 cycles later, PC[7:0] to SP−2. The first write is in cycle 5 for the non-maskable service and in cycle 7 for the others. `new_sp_o` shows SP−2 while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| nmi_i | input | 1 | Non-maskable request line, edge sensitive |
| int_i | input | 1 | Maskable request line, level sensitive |
| insn_end_i | input | 1 | Instruction boundary strobe |
| ev_di_i | input | 1 | Disable event of the finishing instruction |
| ev_ei_i | input | 1 | Enable event |
| ev_im_i | input | 1 | Set-mode event |
| im_sel_i | input | 3 | Mode code field for the set-mode event |
| ev_retn_i | input | 1 | Return-from-NMI event |
| ev_reti_i | input | 1 | Return-from-interrupt event |
| i_reg_i | input | 8 | Table page register |
| pc_i | input | 16 | Program counter to save |
| sp_i | input | 16 | Stack pointer before the push |
| dbus_i | input | 8 | Byte supplied by the peripheral during acknowledge |
| mem_rdata_i | input | 8 | Read data, valid in the cycle of the read |
| mem_re_o | output | 1 | Memory read strobe |
| mem_we_o | output | 1 | Memory write strobe |
| mem_addr_o | output | 16 | Memory address |
| mem_wdata_o | output | 8 | Memory write data |
| ack_o | output | 1 | Acknowledge window |
| busy_o | output | 1 | Service in progress |
| done_o | output | 1 | Last cycle of the service |
| new_pc_o | output | 16 | Target program counter, valid with done |
| new_sp_o | output | 16 | Stack pointer after the push, valid while busy |
| svc_cycles_o | output | 5 | Length of the running service in cycles |
| iff1_o | output | 1 | Enable flip-flop 1 |
| iff2_o | output | 1 | Enable flip-flop 2 |
| imode_o | output | 2 | Current maskable mode |

## Verification
The assertions assume that `insn_end_i` pulses only while `busy_o` is low, and that the event inputs are high only together with `insn_end_i`, at most one at a time. The stimulus keeps to this by raising boundaries only from a task that waits until the sequencer is idle. That task drives each event for exactly the one boundary cycle. The non-maskable line is pulsed between boundaries, so every service is started from a well-defined pending state.

// File: rtl/irq_pkg.sv
// Package: shared service kinds and the mode-code decode used by the
// interrupt sequencer. Assumes nothing beyond a 3-bit mode code.
package irq_pkg;

    typedef enum logic [1:0] {
        SVC_NMI = 2'd0,
        SVC_M0  = 2'd1,
        SVC_M1  = 2'd2,
        SVC_M2  = 2'd3
    } svc_e;

    // Maps the 3-bit mode code to mode 0, 1 or 2 (only the low two bits matter).
    function automatic logic [1:0] im_decode(input logic [2:0] sel);
        logic [1:0] m;
        case (sel[1:0])
            2'b10:   m = 2'd1;
            2'b11:   m = 2'd2;
            default: m = 2'd0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/irq_flags.sv
// Module: enable flip-flops and interrupt mode. Applies the boundary event,
// then the effect of any service accepted at the same boundary.
// Assumes events are high only together with insn_end_i, one at a time.
module irq_flags
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       insn_end_i,
    input  logic       ev_di_i,
    input  logic       ev_ei_i,
    input  logic       ev_im_i,
    input  logic [2:0] im_sel_i,
    input  logic       ev_retn_i,
    input  logic       ev_reti_i,
    input  logic       take_nmi_i,
    input  logic       take_int_i,
    output logic       iff1_o,
    output logic       iff2_o,
    output logic [1:0] mode_o,
    output logic       iff1_eff_o,
    output logic       shadow_o,
    output logic [1:0] mode_eff_o
);

    logic       iff1_q, iff2_q, iff2_eff;
    logic [1:0] mode_q;
    logic       di, ei, ret;

    // Purpose: state as seen after this boundary's event, before any service.
    always_comb begin
        di  = insn_end_i & ev_di_i;
        ei  = insn_end_i & ev_ei_i;
        ret = insn_end_i & (ev_retn_i | ev_reti_i);
        if (di)       iff1_eff_o = 1'b0;
        else if (ei)  iff1_eff_o = 1'b1;
        else if (ret) iff1_eff_o = iff2_q;
        else          iff1_eff_o = iff1_q;
        if (di)       iff2_eff = 1'b0;
        else if (ei)  iff2_eff = 1'b1;
        else          iff2_eff = iff2_q;
        mode_eff_o = (insn_end_i & ev_im_i) ? im_decode(im_sel_i) : mode_q;
        shadow_o   = insn_end_i & (ev_ei_i | ev_retn_i);
    end

    // Purpose: register flip-flops and mode at each boundary.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iff1_q <= 1'b0;
            iff2_q <= 1'b0;
            mode_q <= 2'd0;
        end else if (insn_end_i) begin
            mode_q <= mode_eff_o;
            if (take_nmi_i) begin
                iff1_q <= 1'b0;
                iff2_q <= iff1_eff_o;
            end else if (take_int_i) begin
                iff1_q <= 1'b0;
                iff2_q <= iff2_eff;
            end else begin
                iff1_q <= iff1_eff_o;
                iff2_q <= iff2_eff;
            end
        end
    end

    assign iff1_o = iff1_q;
    assign iff2_o = iff2_q;
    assign mode_o = mode_q;

    AST_DI_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end_i && ev_di_i) |=> (!iff1_q && !iff2_q)); // R1
    AST_NMI_SAVES_IFF1: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end_i && take_nmi_i && !ev_di_i && !ev_ei_i && !ev_retn_i && !ev_reti_i)
        |=> (!iff1_q && iff2_q == $past(iff1_q))); // R3
    AST_RET_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end_i && (ev_retn_i || ev_reti_i) && !take_nmi_i && !take_int_i)
        |=> (iff1_q == $past(iff2_q))); // R4

endmodule

// File: rtl/irq_arbiter.sv
// Module: detects non-maskable edges, keeps them pending, and chooses the
// service at an idle boundary (non-maskable first).
// Assumes the flag block supplies this boundary's effective enable and mode.
module irq_arbiter
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       nmi_i,
    input  logic       int_i,
    input  logic       insn_end_i,
    input  logic       busy_i,
    input  logic       iff1_eff_i,
    input  logic       shadow_i,
    input  logic [1:0] mode_eff_i,
    output logic       take_nmi_o,
    output logic       take_int_o,
    output svc_e       svc_o
);

    logic nmi_prev_q, nmi_pend_q;

    // Purpose: acceptance decision and service kind for this boundary.
    always_comb begin
        take_nmi_o = insn_end_i & ~busy_i & nmi_pend_q;
        take_int_o = insn_end_i & ~busy_i & ~nmi_pend_q & int_i & iff1_eff_i & ~shadow_i;
        if (nmi_pend_q)             svc_o = SVC_NMI;
        else if (mode_eff_i == 2'd1) svc_o = SVC_M1;
        else if (mode_eff_i == 2'd2) svc_o = SVC_M2;
        else                         svc_o = SVC_M0;
    end

    // Purpose: latch rising edges of the non-maskable line until served.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_prev_q <= 1'b0;
            nmi_pend_q <= 1'b0;
        end else begin
            nmi_prev_q <= nmi_i;
            nmi_pend_q <= (nmi_pend_q & ~take_nmi_o) | (nmi_i & ~nmi_prev_q);
        end
    end

    AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (take_nmi_o && int_i) |-> !take_int_o); // R6

endmodule

// File: rtl/irq_ack_seq.sv
// Module: cycle sequencer of one service. Runs the acknowledge window,
// samples the peripheral byte, pushes PC, reads the vector table in mode 2
// and presents the new PC in the last cycle.
// Assumes ADDR_W == 2*DATA_W and a read port that answers in the same cycle.
module irq_ack_seq
    import irq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int FETCH_T = 4,
    parameter int WAIT_T  = 2,
    parameter int CNT_W   = 5,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
    parameter logic [ADDR_W-1:0] M1_VEC  = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  svc_e              svc_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [DATA_W-1:0] i_reg_i,
    input  logic [DATA_W-1:0] dbus_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              busy_o,
    output logic              ack_o,
    output logic              done_o,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic [ADDR_W-1:0] new_pc_o,
    output logic [ADDR_W-1:0] new_sp_o,
    output logic [CNT_W-1:0]  svc_cycles_o
);

    localparam int MEM_T   = 3;
    localparam int PUSH_T  = 2 * MEM_T;
    localparam int ACK_T   = FETCH_T + WAIT_T;
    localparam int NMI_PRE = FETCH_T + 1;
    localparam int MSK_PRE = ACK_T + 1;
    localparam logic [CNT_W-1:0] NMI_TOT = CNT_W'(NMI_PRE + PUSH_T);
    localparam logic [CNT_W-1:0] MSK_TOT = CNT_W'(MSK_PRE + PUSH_T);
    localparam logic [CNT_W-1:0] TBL_TOT = CNT_W'(MSK_PRE + 2 * PUSH_T);
    localparam logic [CNT_W-1:0] ACK_LAST = CNT_W'(ACK_T - 1);
    localparam logic [CNT_W-1:0] RD_LO   = CNT_W'(MSK_PRE + PUSH_T);
    localparam logic [CNT_W-1:0] RD_HI   = CNT_W'(MSK_PRE + PUSH_T + MEM_T);

    logic              busy_q;
    logic [CNT_W-1:0]  cnt_q;
    svc_e              svc_q;
    logic [ADDR_W-1:0] pc_q, sp_q;
    logic [DATA_W-1:0] ireg_q, vec_q, lo_q, hi_q;
    logic              maskable;
    logic [CNT_W-1:0]  pre, total;
    logic              wr_hi, wr_lo, rd_lo, rd_hi;
    logic [ADDR_W-1:0] ptr;

    // Purpose: decode the current cycle of the running service.
    always_comb begin
        maskable = (svc_q != SVC_NMI);
        pre      = maskable ? CNT_W'(MSK_PRE) : CNT_W'(NMI_PRE);
        case (svc_q)
            SVC_NMI: total = NMI_TOT;
            SVC_M2:  total = TBL_TOT;
            default: total = MSK_TOT;
        endcase
        wr_hi = busy_q && (cnt_q == pre);
        wr_lo = busy_q && (cnt_q == pre + CNT_W'(MEM_T));
        rd_lo = busy_q && (svc_q == SVC_M2) && (cnt_q == RD_LO);
        rd_hi = busy_q && (svc_q == SVC_M2) && (cnt_q == RD_HI);
        ptr   = {ireg_q, vec_q} & ~ADDR_W'(1);
    end

    // Purpose: service counter and captured operands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            svc_q  <= SVC_NMI;
            pc_q   <= '0;
            sp_q   <= '0;
            ireg_q <= '0;
            vec_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
        end else if (!busy_q) begin
            if (start_i) begin
                busy_q <= 1'b1;
                cnt_q  <= '0;
                svc_q  <= svc_i;
                pc_q   <= pc_i;
                sp_q   <= sp_i;
                ireg_q <= i_reg_i;
            end
        end else begin
            if (cnt_q == total - CNT_W'(1)) busy_q <= 1'b0;
            else                             cnt_q  <= cnt_q + CNT_W'(1);
            if (maskable && cnt_q == ACK_LAST) vec_q <= dbus_i;
            if (rd_lo) lo_q <= mem_rdata_i;
            if (rd_hi) hi_q <= mem_rdata_i;
        end
    end

    // Purpose: memory port drive for the push and the table reads.
    always_comb begin
        mem_we_o    = wr_hi | wr_lo;
        mem_re_o    = rd_lo | rd_hi;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        if (wr_hi) begin
            mem_addr_o  = sp_q - ADDR_W'(1);
            mem_wdata_o = pc_q[ADDR_W-1:DATA_W];
        end else if (wr_lo) begin
            mem_addr_o  = sp_q - ADDR_W'(2);
            mem_wdata_o = pc_q[DATA_W-1:0];
        end else if (rd_lo) begin
            mem_addr_o  = ptr;
        end else if (rd_hi) begin
            mem_addr_o  = ptr + ADDR_W'(1);
        end
    end

    // Purpose: status outputs and the target program counter.
    always_comb begin
        busy_o       = busy_q;
        ack_o        = busy_q && maskable && (cnt_q < CNT_W'(ACK_T));
        done_o       = busy_q && (cnt_q == total - CNT_W'(1));
        new_sp_o     = busy_q ? sp_q - ADDR_W'(2) : '0;
        svc_cycles_o = busy_q ? total : '0;
        new_pc_o     = '0;
        if (done_o) begin
            case (svc_q)
                SVC_NMI: new_pc_o = NMI_VEC;
                SVC_M1:  new_pc_o = M1_VEC;
                SVC_M0:  new_pc_o = ADDR_W'({vec_q[5:3], 3'b000});
                default: new_pc_o = {hi_q, lo_q};
            endcase
        end
    end

    AST_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |-> !busy_q); // R8
    AST_PUSH_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && cnt_q == pre) |-> (mem_we_o && mem_addr_o == sp_q - ADDR_W'(1))); // R12

endmodule

// File: rtl/irq_ack_sequencer.sv
// Module: top of the interrupt enable and acknowledge sequencer.
// Assumes insn_end_i only while busy_o is low and at most one event per boundary.
module irq_ack_sequencer
    import irq_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int DATA_W  = 8,
    parameter int FETCH_T = 4,
    parameter int WAIT_T  = 2,
    parameter int CNT_W   = 5,
    parameter logic [ADDR_W-1:0] NMI_VEC = 16'h0066,
    parameter logic [ADDR_W-1:0] M1_VEC  = 16'h0038
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              nmi_i,
    input  logic              int_i,
    input  logic              insn_end_i,
    input  logic              ev_di_i,
    input  logic              ev_ei_i,
    input  logic              ev_im_i,
    input  logic [2:0]        im_sel_i,
    input  logic              ev_retn_i,
    input  logic              ev_reti_i,
    input  logic [DATA_W-1:0] i_reg_i,
    input  logic [ADDR_W-1:0] pc_i,
    input  logic [ADDR_W-1:0] sp_i,
    input  logic [DATA_W-1:0] dbus_i,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              mem_re_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o,
    output logic              ack_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [ADDR_W-1:0] new_pc_o,
    output logic [ADDR_W-1:0] new_sp_o,
    output logic [CNT_W-1:0]  svc_cycles_o,
    output logic              iff1_o,
    output logic              iff2_o,
    output logic [1:0]        imode_o
);

    logic       take_nmi, take_int, iff1_eff, shadow;
    logic [1:0] mode_eff;
    svc_e       svc;

    irq_flags u_flags (
        .clk(clk), .rst_n(rst_n), .insn_end_i(insn_end_i),
        .ev_di_i(ev_di_i), .ev_ei_i(ev_ei_i), .ev_im_i(ev_im_i),
        .im_sel_i(im_sel_i), .ev_retn_i(ev_retn_i), .ev_reti_i(ev_reti_i),
        .take_nmi_i(take_nmi), .take_int_i(take_int),
        .iff1_o(iff1_o), .iff2_o(iff2_o), .mode_o(imode_o),
        .iff1_eff_o(iff1_eff), .shadow_o(shadow), .mode_eff_o(mode_eff)
    );

    irq_arbiter u_arb (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi_i), .int_i(int_i),
        .insn_end_i(insn_end_i), .busy_i(busy_o), .iff1_eff_i(iff1_eff),
        .shadow_i(shadow), .mode_eff_i(mode_eff),
        .take_nmi_o(take_nmi), .take_int_o(take_int), .svc_o(svc)
    );

    irq_ack_seq #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .FETCH_T(FETCH_T), .WAIT_T(WAIT_T),
        .CNT_W(CNT_W), .NMI_VEC(NMI_VEC), .M1_VEC(M1_VEC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(take_nmi | take_int), .svc_i(svc),
        .pc_i(pc_i), .sp_i(sp_i), .i_reg_i(i_reg_i), .dbus_i(dbus_i),
        .mem_rdata_i(mem_rdata_i), .busy_o(busy_o), .ack_o(ack_o),
        .done_o(done_o), .mem_re_o(mem_re_o), .mem_we_o(mem_we_o),
        .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
        .new_pc_o(new_pc_o), .new_sp_o(new_sp_o), .svc_cycles_o(svc_cycles_o)
    );

    AST_MASKED_IN_SERVICE: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !iff1_o); // R5
    AST_EI_SHADOW: assert property (@(posedge clk) disable iff (!rst_n)
        (insn_end_i && (ev_ei_i || ev_retn_i)) |=> !busy_o || svc_cycles_o == CNT_W'(FETCH_T + 7)); // R2
    AST_BOUNDARY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        insn_end_i |-> !busy_o); // R8

endmodule

// File: tb/test_irq_ack_sequencer.sv
module test_irq_ack_sequencer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        nmi = 0, intr = 0, insn_end = 0;
    logic        ev_di = 0, ev_ei = 0, ev_im = 0, ev_retn = 0, ev_reti = 0;
    logic [2:0]  im_sel = 0;
    logic [7:0]  ireg = 0, dbus = 0;
    logic [15:0] pc = 16'h1234, sp = 16'h8000;
    logic [7:0]  rdata;
    logic        mem_re, mem_we, ack, busy, done, iff1, iff2;
    logic [15:0] mem_addr, new_pc, new_sp;
    logic [7:0]  mem_wdata;
    logic [4:0]  svc_cycles;
    logic [1:0]  imode;

    always #4 clk = ~clk;

    // Bench memory: content computed from the address.
    function automatic int rd_fn(input int a);
        return ((a & 255) ^ ((a >> 8) & 255) ^ 8'h5A);
    endfunction
    assign rdata = 8'(rd_fn(int'(mem_addr)));

    irq_ack_sequencer i_irq_ack_sequencer (
        .clk(clk), .rst_n(rst_n), .nmi_i(nmi), .int_i(intr), .insn_end_i(insn_end),
        .ev_di_i(ev_di), .ev_ei_i(ev_ei), .ev_im_i(ev_im), .im_sel_i(im_sel),
        .ev_retn_i(ev_retn), .ev_reti_i(ev_reti), .i_reg_i(ireg), .pc_i(pc),
        .sp_i(sp), .dbus_i(dbus), .mem_rdata_i(rdata), .mem_re_o(mem_re),
        .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
        .ack_o(ack), .busy_o(busy), .done_o(done), .new_pc_o(new_pc),
        .new_sp_o(new_sp), .svc_cycles_o(svc_cycles), .iff1_o(iff1),
        .iff2_o(iff2), .imode_o(imode)
    );

    int n_chk = 0, n_fail = 0;
    int n_done = 0, last_pc = 0, last_cyc = 0, last_ack = 0, ack_run = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model state (service kind: 0 nmi, 1 mode0, 2 mode1, 3 mode2).
    int m_iff1, m_iff2, m_mode, m_pend, m_prev, m_busy, m_t, m_svc;
    int m_pc, m_sp, m_i, m_vec, m_lo, m_hi;

    function automatic int tot(input int s);
        return (s == 0) ? 11 : (s == 3) ? 19 : 13;
    endfunction
    function automatic int mode_of(input int sel);
        case (sel)
            2, 6:    return 1;
            3, 7:    return 2;
            default: return 0;
        endcase
    endfunction

    // Model advance on each rising edge.
    always @(posedge clk) begin
        int e1, e2, md, cur, ptr;
        bit tn, ti;
        if (!rst_n) begin
            m_iff1 = 0; m_iff2 = 0; m_mode = 0; m_pend = 0; m_prev = 0;
            m_busy = 0; m_t = 0; m_svc = 0; m_vec = 0; m_lo = 0; m_hi = 0;
        end else begin
            if (m_busy != 0) begin
                cur = m_t;
                ptr = m_i * 256 + (m_vec & 'hFE);
                if (m_svc != 0 && cur == 5) m_vec = int'(dbus);
                if (m_svc == 3 && cur == 13) m_lo = rd_fn(ptr);
                if (m_svc == 3 && cur == 16) m_hi = rd_fn(ptr + 1);
                if (cur == tot(m_svc) - 1) m_busy = 0; else m_t = cur + 1;
            end else if (insn_end) begin
                e1 = ev_di ? 0 : ev_ei ? 1 : (ev_retn || ev_reti) ? m_iff2 : m_iff1;
                e2 = ev_di ? 0 : ev_ei ? 1 : m_iff2;
                md = ev_im ? mode_of(int'(im_sel)) : m_mode;
                tn = (m_pend != 0);
                ti = !tn && intr && (e1 != 0) && !ev_ei && !ev_retn;
                m_mode = md;
                if (tn) begin m_iff2 = e1; m_iff1 = 0; m_pend = 0; end
                else if (ti) begin m_iff1 = 0; m_iff2 = e2; end
                else begin m_iff1 = e1; m_iff2 = e2; end
                if (tn || ti) begin
                    m_busy = 1; m_t = 0;
                    m_svc = tn ? 0 : md + 1;
                    m_pc = int'(pc); m_sp = int'(sp); m_i = int'(ireg);
                end
            end
            if (nmi && m_prev == 0) m_pend = 1;
            m_prev = nmi;
        end
    end

    // Compare against the model every cycle, away from the rising edge.
    always @(negedge clk) begin
        int pre, exp_pc;
        bit last;
        if (rst_n) begin
            check("R1", "iff1", int'(iff1), m_iff1);
            check("R1", "iff2", int'(iff2), m_iff2);
            check("R7", "imode", int'(imode), m_mode);
            check("R8", "busy", int'(busy), m_busy);
            last = (m_busy != 0) && (m_t == tot(m_svc) - 1);
            pre  = (m_svc == 0) ? 5 : 7;
            check("R8", "ack", int'(ack), int'((m_busy != 0) && m_svc != 0 && m_t < 6));
            check("R8", "done", int'(done), int'(last));
            check("R12", "we", int'(mem_we), int'((m_busy != 0) && (m_t == pre || m_t == pre + 3)));
            check("R11", "re", int'(mem_re), int'((m_busy != 0) && m_svc == 3 && (m_t == 13 || m_t == 16)));
            if (m_busy != 0) begin
                check("R12", "new_sp", int'(new_sp), (m_sp - 2) & 'hFFFF);
                check("R9", "svc_cycles", int'(svc_cycles), tot(m_svc));
                if (m_t == pre) begin
                    check("R12", "hi addr", int'(mem_addr), (m_sp - 1) & 'hFFFF);
                    check("R12", "hi data", int'(mem_wdata), (m_pc >> 8) & 255);
                end
                if (m_t == pre + 3) begin
                    check("R12", "lo addr", int'(mem_addr), (m_sp - 2) & 'hFFFF);
                    check("R12", "lo data", int'(mem_wdata), m_pc & 255);
                end
                if (m_svc == 3 && m_t == 13)
                    check("R11", "ptr lo", int'(mem_addr), m_i * 256 + (m_vec & 'hFE));
                if (m_svc == 3 && m_t == 16)
                    check("R11", "ptr hi", int'(mem_addr), m_i * 256 + (m_vec & 'hFE) + 1);
                if (last) begin
                    case (m_svc)
                        0: exp_pc = 'h0066;
                        1: exp_pc = ((m_vec >> 3) & 7) * 8;
                        2: exp_pc = 'h0038;
                        default: exp_pc = m_hi * 256 + m_lo;
                    endcase
                    check(m_svc == 0 ? "R3" : m_svc == 1 ? "R9" : m_svc == 2 ? "R10" : "R11",
                          "new_pc", int'(new_pc), exp_pc);
                end
            end
            if (ack) ack_run++;
            if (done) begin
                n_done++; last_pc = int'(new_pc); last_cyc = int'(svc_cycles);
                last_ack = ack_run; ack_run = 0;
            end
        end
    end

    // One instruction boundary with event code: 0 none, 1 di, 2 ei, 3 im, 4 retn, 5 reti.
    task automatic boundary(input int ev);
        @(negedge clk); #1;
        insn_end = 1; ev_di = (ev == 1); ev_ei = (ev == 2); ev_im = (ev == 3);
        ev_retn = (ev == 4); ev_reti = (ev == 5);
        @(negedge clk); #1;
        insn_end = 0; ev_di = 0; ev_ei = 0; ev_im = 0; ev_retn = 0; ev_reti = 0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_nmi();
        @(negedge clk); #1; nmi = 1;
        @(negedge clk); #1; nmi = 0;
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        n_chk++; n_fail++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        int nd;
        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check("R1", "reset iff1", int'(iff1), 0);
        check("R1", "reset iff2", int'(iff2), 0);
        check("R7", "reset mode", int'(imode), 0);

        // R7: every mode code
        for (int s = 0; s < 8; s++) begin
            im_sel = 3'(s);
            boundary(3);
            check("R7", "mode code", int'(imode), (s % 4 == 2) ? 1 : (s % 4 == 3) ? 2 : 0);
        end
        im_sel = 3'b110; boundary(3);

        // R2: enable shadow then mode 1 service
        intr = 1; nd = n_done;
        boundary(2);
        check("R2", "no take at enable", n_done, nd);
        check("R1", "enable iff1", int'(iff1), 1);
        check("R1", "enable iff2", int'(iff2), 1);
        boundary(0);
        check("R2", "take after shadow", n_done, nd + 1);
        check("R10", "mode1 pc", last_pc, 'h0038);
        check("R10", "mode1 cycles", last_cyc, 13);
        check("R8", "ack length", last_ack, 6);
        check("R5", "iff1 cleared", int'(iff1), 0);
        check("R5", "iff2 kept", int'(iff2), 1);
        nd = n_done;
        boundary(0);
        check("R5", "ignored while masked", n_done, nd);
        intr = 0; boundary(5);
        check("R4", "reti restores", int'(iff1), 1);

        // R3: non-maskable service
        pc = 16'hA5C3; sp = 16'h4000;
        pulse_nmi(); boundary(0);
        check("R3", "nmi pc", last_pc, 'h0066);
        check("R3", "nmi cycles", last_cyc, 11);
        check("R3", "nmi iff1", int'(iff1), 0);
        check("R3", "nmi iff2", int'(iff2), 1);
        intr = 1; nd = n_done;
        boundary(4);
        check("R4", "no take at retn", n_done, nd);
        check("R4", "retn restores", int'(iff1), 1);
        boundary(0);
        check("R4", "take after retn", n_done, nd + 1);
        intr = 0; boundary(5);

        // R11: table mode
        im_sel = 3'b011; boundary(3);
        ireg = 8'h3C; dbus = 8'h97; pc = 16'h0F0E; sp = 16'hFF00; intr = 1;
        boundary(0);
        check("R11", "table pc", last_pc, 'hF1F0);
        check("R11", "table cycles", last_cyc, 19);
        intr = 0; boundary(5);

        // R9: restart mode
        im_sel = 3'b100; boundary(3);
        dbus = 8'hEF; intr = 1;
        boundary(0);
        check("R9", "restart pc", last_pc, 'h0028);
        check("R9", "restart cycles", last_cyc, 13);
        intr = 0; boundary(5);

        // R6: both pending
        pulse_nmi(); intr = 1;
        boundary(0);
        check("R6", "nmi wins pc", last_pc, 'h0066);
        check("R6", "nmi wins cycles", last_cyc, 11);
        nd = n_done;
        boundary(0);
        check("R5", "int masked after nmi", n_done, nd);
        intr = 0; boundary(4);

        // R1 disable, R3 unmaskable
        boundary(2); boundary(1);
        check("R1", "disable iff1", int'(iff1), 0);
        check("R1", "disable iff2", int'(iff2), 0);
        nd = n_done;
        pulse_nmi(); boundary(0);
        check("R3", "nmi while disabled", n_done, nd + 1);
        check("R3", "saved iff2", int'(iff2), 0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule